// File: doc/BRIEF.md
# Egress Descriptor Ring Post Engine

This block keeps the pointer state of up to 64 egress descriptor rings. Software hands descriptors to hardware with a memory-mapped store. The store names the ring in its address and carries two values in its data: the tail index the ring had before the post, and how many descriptors follow it. The engine stores the new tail and raises a per-ring fetch request towards an external descriptor fetcher. The fetcher answers with a one-ring-per-cycle acknowledge. Each acknowledge moves that ring's head pointer forward by one slot. A generation bit flips every time the head wraps back to slot 0. A descriptor is valid when it carries the inverse of that bit.

The fetcher, or a later stage, reports fully processed descriptors on a completion port, and the engine adds them to a rolling 16-bit counter. A memory-mapped load on the same region returns the head pointer, the completed counter and the generation bit. A side configuration port sets each ring's size as a log2 value and drives a per-ring flush bit. Clearing the flush bit zeroes the completed counter. A post with a zero count wakes a ring so the fetcher looks at it even when head equals tail. A post of a whole ring's worth of descriptors is also recognised as pending work.

Top module: `egr_post_engine`

## Requirements
- R1: A bus access is accepted only when address bits 28:26 equal 5. The ring number is taken from address bits 8:3. An access with any other region code changes no ring and produces no read response.
- R2: A store writes the new tail as (data bits 15:0 + data bits 31:16) masked to the ring size. Index bits above the ring size are ignored.
- R3: A store whose count equals the ring size leaves tail equal to head, but still counts as a full ring. The fetch request stays high for exactly ring-size acknowledges.
- R4: A store with a count of zero raises that ring's fetch request even when head equals tail. The next acknowledge for the ring clears this wake-up without moving the head.
- R5: fetch_req[r] is high exactly while ring r has head different from tail, a pending wake-up, or a pending full ring. Each fetch_ack for ring r with work pending moves the head one slot forward, modulo the ring size. An acknowledge with no work pending leaves the head unchanged.
- R6: The generation bit of a ring toggles each time its head wraps from the last slot to slot 0. It is 0 after reset.
- R7: A load returns one cycle later with bus_rvalid high. The data holds the head in bits 15:0, the completed count in bits 31:16 and the generation in bit 32.
- R8: A completion report adds cmpl_count to the ring's completed counter, modulo 2^16.
- R9: A configuration write that moves a ring's flush bit from 1 to 0 sets its completed counter to zero. A configuration write that leaves the flush bit at 0, or sets it, keeps the counter.
- R10: A configuration write sets the ring size to 2^cfg_log2, with cfg_log2 clamped to the range 2..16. It returns head, tail, generation, wake-up and full state to zero. After reset every ring has size 2^16 and all state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Memory-mapped access strobe |
| bus_write | input | 1 | 1 = store (post), 0 = load (status read) |
| bus_addr | input | 32 | Access address: region in bits 28:26, ring in bits 8:3 |
| bus_wdata | input | 32 | Store data: tail index before the post in 15:0, descriptor count in 31:16 |
| bus_rdata | output | 33 | Load data: head in 15:0, completed count in 31:16, generation in 32 |
| bus_rvalid | output | 1 | Load response valid, one cycle after the load |
| cfg_wr | input | 1 | Ring configuration write strobe |
| cfg_ring | input | 6 | Ring being configured |
| cfg_log2 | input | 5 | Log2 of the ring size (clamped to 2..16) |
| cfg_flush | input | 1 | New value of the ring's flush bit |
| fetch_req | output | 64 | Per-ring request to the descriptor fetcher |
| fetch_ack | input | 1 | Fetcher took one descriptor slot |
| fetch_ack_ring | input | 6 | Ring of the acknowledge |
| cmpl_valid | input | 1 | Completion report strobe |
| cmpl_ring | input | 6 | Ring of the completion report |
| cmpl_count | input | 16 | Descriptors completed in this report |

## Verification
The hardest state to reach is a post of exactly one ring's worth of descriptors. Tail then equals head, and only the stored full indication keeps the request alive. The bench configures a four-slot ring, posts a count of four, and counts acknowledges until the request drops, checking that the head has wrapped and the generation has flipped. The rolling completed counter is driven past 2^16 with two reports whose sum overflows. The flush edge is reached by setting and then clearing the bit after a count has built up.

// File: rtl/egr_post_pkg.sv
// Package egr_post_pkg
// Shared types for the egress ring post engine.
// Assumes nothing beyond the single-operation-per-cycle bus used by the top.
package egr_post_pkg;

    // Kind of memory-mapped operation seen on the bus in one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_POST = 2'd1,
        OP_LOAD = 2'd2
    } bus_op_e;

endpackage

// File: rtl/egr_bus_decode.sv
// Module egr_bus_decode
// Turns one bus access into a post or load operation and a ring number.
// Assumes the region code sits at REGION_LO and the ring number at RING_LO.
// An access with a foreign region code becomes OP_IDLE.
module egr_bus_decode
    import egr_post_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int RING_W      = 6,
    parameter int RING_LO     = 3,
    parameter int REGION_LO   = 26,
    parameter int REGION_W    = 3,
    parameter int REGION_CODE = 5
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_op_e           op,
    output logic [RING_W-1:0] ring
);
    logic region_hit;
    logic unused_addr_bits;

    assign unused_addr_bits = ^bus_addr;
    assign region_hit = (bus_addr[REGION_LO +: REGION_W] == REGION_W'(REGION_CODE));
    assign ring       = bus_addr[RING_LO +: RING_W];

    // Classify the access
    always_comb begin
        op = OP_IDLE;
        if (bus_valid && region_hit) begin
            op = bus_write ? OP_POST : OP_LOAD;
        end
    end
endmodule

// File: rtl/egr_ring_slot.sv
// Module egr_ring_slot
// Pointer state of one descriptor ring: head, tail, generation, wake-up,
// full-ring flag, completed counter, size and flush bit.
// Assumes at most one post, one acknowledge, one completion and one
// configuration write per cycle. Within a cycle they are applied in the
// order ack, post, completion, configuration.
module egr_ring_slot #(
    parameter int IDX_W    = 16,
    parameter int CNT_W    = 16,
    parameter int LOG2_W   = 5,
    parameter int MIN_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_hit,
    input  logic [IDX_W-1:0]  post_idx,
    input  logic [CNT_W-1:0]  post_cnt,
    input  logic              ack_hit,
    input  logic              cmpl_hit,
    input  logic [CNT_W-1:0]  cmpl_cnt,
    input  logic              cfg_hit,
    input  logic [LOG2_W-1:0] cfg_log2,
    input  logic              cfg_flush,
    output logic [IDX_W-1:0]  head,
    output logic [CNT_W-1:0]  done_cnt,
    output logic              gen,
    output logic              fetch_req
);
    logic [IDX_W-1:0]  head_q, tail_q, head_d, tail_d;
    logic [CNT_W-1:0]  done_q, done_d;
    logic              gen_q, gen_d, wake_q, wake_d, full_q, full_d, flush_q, flush_d;
    logic [LOG2_W-1:0] size_q, size_d, cfg_clamped;
    logic [IDX_W:0]    one_sh;
    logic [IDX_W-1:0]  mask;

    // Slot mask for the current ring size
    assign one_sh = (IDX_W+1)'(1) << size_q;
    assign mask   = one_sh[IDX_W-1:0] - {{(IDX_W-1){1'b0}}, 1'b1};

    // Clamp the requested log2 size into the legal range
    always_comb begin
        cfg_clamped = cfg_log2;
        if (cfg_log2 < LOG2_W'(MIN_LOG2)) cfg_clamped = LOG2_W'(MIN_LOG2);
        if (cfg_log2 > LOG2_W'(IDX_W))    cfg_clamped = LOG2_W'(IDX_W);
    end

    // Next state: ack, then post, then completion, then configuration
    always_comb begin
        head_d  = head_q;
        tail_d  = tail_q;
        done_d  = done_q;
        gen_d   = gen_q;
        wake_d  = wake_q;
        full_d  = full_q;
        flush_d = flush_q;
        size_d  = size_q;
        if (ack_hit) begin
            if (head_q != tail_q || full_q) begin
                head_d = (head_q + {{(IDX_W-1){1'b0}}, 1'b1}) & mask;
                full_d = 1'b0;
                if (head_d == '0) gen_d = ~gen_q;
            end
            wake_d = 1'b0;
        end
        if (post_hit) begin
            tail_d = ((post_idx & mask) + IDX_W'(post_cnt)) & mask;
            if (post_cnt == '0) begin
                wake_d = 1'b1;
            end else begin
                full_d = (tail_d == head_d);
            end
        end
        if (cmpl_hit) begin
            done_d = done_d + cmpl_cnt;
        end
        if (cfg_hit) begin
            if (flush_q && !cfg_flush) done_d = '0;
            flush_d = cfg_flush;
            size_d  = cfg_clamped;
            head_d  = '0;
            tail_d  = '0;
            gen_d   = 1'b0;
            wake_d  = 1'b0;
            full_d  = 1'b0;
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            done_q  <= '0;
            gen_q   <= 1'b0;
            wake_q  <= 1'b0;
            full_q  <= 1'b0;
            flush_q <= 1'b0;
            size_q  <= LOG2_W'(IDX_W);
        end else begin
            head_q  <= head_d;
            tail_q  <= tail_d;
            done_q  <= done_d;
            gen_q   <= gen_d;
            wake_q  <= wake_d;
            full_q  <= full_d;
            flush_q <= flush_d;
            size_q  <= size_d;
        end
    end

    assign head      = head_q;
    assign done_cnt  = done_q;
    assign gen       = gen_q;
    assign fetch_req = (head_q != tail_q) || wake_q || full_q;
endmodule

// File: rtl/egr_read_port.sv
// Module egr_read_port
// Registered status read: selects one ring's head, completed count and
// generation, and returns them one cycle after the load.
// Assumes the ring number is already decoded and in range.
module egr_read_port #(
    parameter int NRINGS = 64,
    parameter int RING_W = 6,
    parameter int IDX_W  = 16,
    parameter int CNT_W  = 16,
    localparam int RD_W  = IDX_W + CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [RING_W-1:0] ring,
    input  logic [IDX_W-1:0]  head_a [NRINGS],
    input  logic [CNT_W-1:0]  done_a [NRINGS],
    input  logic              gen_a  [NRINGS],
    output logic [RD_W-1:0]   rdata,
    output logic              rvalid
);
    // Capture the selected ring's status on a load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= load;
            if (load) rdata <= {gen_a[ring], done_a[ring], head_a[ring]};
        end
    end
endmodule

// File: rtl/egr_post_engine.sv
// Module egr_post_engine (top)
// Egress descriptor ring post engine: decodes memory-mapped posts and
// loads, keeps per-ring pointer state and drives per-ring fetch requests.
// Assumes one bus access, one fetch acknowledge, one completion and one
// configuration write at most per cycle, each naming a single ring.
module egr_post_engine #(
    parameter int RING_W      = 6,
    parameter int IDX_W       = 16,
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 32,
    parameter int REGION_LO   = 26,
    parameter int REGION_CODE = 5,
    parameter int RING_LO     = 3,
    localparam int NRINGS     = 1 << RING_W,
    localparam int LOG2_W     = $clog2(IDX_W + 1),
    localparam int WR_W       = IDX_W + CNT_W,
    localparam int RD_W       = IDX_W + CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WR_W-1:0]   bus_wdata,
    output logic [RD_W-1:0]   bus_rdata,
    output logic              bus_rvalid,
    input  logic              cfg_wr,
    input  logic [RING_W-1:0] cfg_ring,
    input  logic [LOG2_W-1:0] cfg_log2,
    input  logic              cfg_flush,
    output logic [NRINGS-1:0] fetch_req,
    input  logic              fetch_ack,
    input  logic [RING_W-1:0] fetch_ack_ring,
    input  logic              cmpl_valid,
    input  logic [RING_W-1:0] cmpl_ring,
    input  logic [CNT_W-1:0]  cmpl_count
);
    import egr_post_pkg::*;

    bus_op_e           op;
    logic [RING_W-1:0] bus_ring;
    logic [IDX_W-1:0]  head_a [NRINGS];
    logic [CNT_W-1:0]  done_a [NRINGS];
    logic              gen_a  [NRINGS];

    egr_bus_decode #(
        .ADDR_W(ADDR_W), .RING_W(RING_W), .RING_LO(RING_LO),
        .REGION_LO(REGION_LO), .REGION_W(3), .REGION_CODE(REGION_CODE)
    ) u_decode (
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .op(op), .ring(bus_ring)
    );

    for (genvar r = 0; r < NRINGS; r++) begin : g_ring
        egr_ring_slot #(
            .IDX_W(IDX_W), .CNT_W(CNT_W), .LOG2_W(LOG2_W), .MIN_LOG2(2)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .post_hit(op == OP_POST && bus_ring == RING_W'(r)),
            .post_idx(bus_wdata[IDX_W-1:0]),
            .post_cnt(bus_wdata[WR_W-1:IDX_W]),
            .ack_hit(fetch_ack && fetch_ack_ring == RING_W'(r)),
            .cmpl_hit(cmpl_valid && cmpl_ring == RING_W'(r)),
            .cmpl_cnt(cmpl_count),
            .cfg_hit(cfg_wr && cfg_ring == RING_W'(r)),
            .cfg_log2(cfg_log2),
            .cfg_flush(cfg_flush),
            .head(head_a[r]),
            .done_cnt(done_a[r]),
            .gen(gen_a[r]),
            .fetch_req(fetch_req[r])
        );
    end

    egr_read_port #(
        .NRINGS(NRINGS), .RING_W(RING_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_read (
        .clk(clk), .rst_n(rst_n),
        .load(op == OP_LOAD), .ring(bus_ring),
        .head_a(head_a), .done_a(done_a), .gen_a(gen_a),
        .rdata(bus_rdata), .rvalid(bus_rvalid)
    );
endmodule

// File: rtl/egr_post_engine_chk.sv
// Module egr_post_engine_chk
// Port-level properties of the post engine, bound to the top module.
// Assumes the top's default field positions for region and ring.
module egr_post_engine_chk #(
    parameter int RING_W      = 6,
    parameter int ADDR_W      = 32,
    parameter int REGION_LO   = 26,
    parameter int REGION_CODE = 5,
    parameter int RING_LO     = 3,
    localparam int NRINGS     = 1 << RING_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic              cfg_wr,
    input logic [RING_W-1:0] cfg_ring,
    input logic [NRINGS-1:0] fetch_req
);
    logic              in_region;
    logic [RING_W-1:0] a_ring;
    logic              load_seen, post_seen;

    assign in_region = (bus_addr[REGION_LO +: 3] == 3'(REGION_CODE));
    assign a_ring    = bus_addr[RING_LO +: RING_W];
    assign load_seen = bus_valid && !bus_write && in_region;
    assign post_seen = bus_valid && bus_write && in_region;

    // R7
    load_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_seen |=> bus_rvalid);

    // R1
    foreign_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_seen |=> !bus_rvalid);

    // R5
    post_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_seen && !(cfg_wr && cfg_ring == a_ring)) |=> fetch_req[$past(a_ring)]);

    // R10
    cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !fetch_req[$past(cfg_ring)]);
endmodule

bind egr_post_engine egr_post_engine_chk #(
    .RING_W(RING_W), .ADDR_W(ADDR_W), .REGION_LO(REGION_LO),
    .REGION_CODE(REGION_CODE), .RING_LO(RING_LO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .cfg_wr(cfg_wr),
    .cfg_ring(cfg_ring), .fetch_req(fetch_req)
);

// File: tb/test_egr_post_engine.sv
// Directed bench for egr_post_engine: one task per scenario.
module test_egr_post_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [32:0] bus_rdata;
    logic        bus_rvalid;
    logic        cfg_wr = 1'b0, cfg_flush = 1'b0;
    logic [5:0]  cfg_ring = '0, fetch_ack_ring = '0, cmpl_ring = '0;
    logic [4:0]  cfg_log2 = '0;
    logic [63:0] fetch_req;
    logic        fetch_ack = 1'b0, cmpl_valid = 1'b0;
    logic [15:0] cmpl_count = '0;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    egr_post_engine i_egr_post_engine (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cfg_wr(cfg_wr), .cfg_ring(cfg_ring),
        .cfg_log2(cfg_log2), .cfg_flush(cfg_flush), .fetch_req(fetch_req),
        .fetch_ack(fetch_ack), .fetch_ack_ring(fetch_ack_ring),
        .cmpl_valid(cmpl_valid), .cmpl_ring(cmpl_ring), .cmpl_count(cmpl_count)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input int region, input int ring);
        return (32'(region) << 26) | (32'(ring) << 3);
    endfunction

    task automatic post(input int ring, input int idx, input int cnt, input int region = 5);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = addr_of(region, ring);
        bus_wdata = {16'(cnt), 16'(idx)};
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic load(input int ring, output logic [32:0] data, output logic valid,
                        input int region = 5);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = addr_of(region, ring);
        @(negedge clk);
        bus_valid = 1'b0;
        data = bus_rdata; valid = bus_rvalid;
    endtask

    task automatic ack(input int ring);
        @(negedge clk);
        fetch_ack = 1'b1; fetch_ack_ring = 6'(ring);
        @(negedge clk);
        fetch_ack = 1'b0;
    endtask

    task automatic cfg(input int ring, input int lg, input bit fl);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_ring = 6'(ring); cfg_log2 = 5'(lg); cfg_flush = fl;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cmpl(input int ring, input int n);
        @(negedge clk);
        cmpl_valid = 1'b1; cmpl_ring = 6'(ring); cmpl_count = 16'(n);
        @(negedge clk);
        cmpl_valid = 1'b0;
    endtask

    function automatic logic [32:0] view(input bit g, input int c, input int h);
        return {g, 16'(c), 16'(h)};
    endfunction

    task automatic t_reset;
        logic [32:0] d; logic v;
        check("R10 reset fetch_req", fetch_req, 64'h0);
        load(0, d, v);
        check("R7 reset load valid", 64'(v), 64'h1);
        check("R10 reset ring0 status", 64'(d), 64'(view(0, 0, 0)));
    endtask

    task automatic t_basic_and_wrap;
        logic [32:0] d; logic v;
        cfg(3, 2, 0);
        post(3, 0, 3);
        check("R5 request after post", 64'(fetch_req[3]), 64'h1);
        for (int i = 0; i < 3; i++) ack(3);
        check("R5 request drops at tail", 64'(fetch_req[3]), 64'h0);
        load(3, d, v);
        check("R5 head after three acks", 64'(d), 64'(view(0, 0, 3)));
        post(3, 3, 2);
        ack(3);
        load(3, d, v);
        check("R6 gen flips on wrap", 64'(d), 64'(view(1, 0, 0)));
        ack(3);
        check("R2 wrapped tail reached", 64'(fetch_req[3]), 64'h0);
        load(3, d, v);
        check("R7 status fields", 64'(d), 64'(view(1, 0, 1)));
        ack(3);
        load(3, d, v);
        check("R5 idle ack keeps head", 64'(d), 64'(view(1, 0, 1)));
    endtask

    task automatic t_full_ring;
        logic [32:0] d; logic v;
        cfg(5, 2, 0);
        post(5, 0, 4);
        check("R3 full post requests", 64'(fetch_req[5]), 64'h1);
        for (int i = 0; i < 3; i++) ack(5);
        check("R3 still pending after 3", 64'(fetch_req[5]), 64'h1);
        ack(5);
        check("R3 done after 4", 64'(fetch_req[5]), 64'h0);
        load(5, d, v);
        check("R3 R6 head and gen", 64'(d), 64'(view(1, 0, 0)));
    endtask

    task automatic t_wake;
        logic [32:0] d; logic v;
        post(7, 0, 0);
        check("R4 wake request", 64'(fetch_req[7]), 64'h1);
        ack(7);
        check("R4 wake cleared", 64'(fetch_req[7]), 64'h0);
        load(7, d, v);
        check("R4 head unmoved", 64'(d), 64'(view(0, 0, 0)));
    endtask

    task automatic t_completion_flush;
        logic [32:0] d; logic v;
        cmpl(3, 10);
        cmpl(3, 16'hFFFA);
        load(3, d, v);
        check("R8 rolling count", 64'(d), 64'(view(1, 4, 1)));
        cfg(3, 2, 1);
        load(3, d, v);
        check("R9 setting flush keeps count", 64'(d), 64'(view(0, 4, 0)));
        cfg(3, 2, 0);
        load(3, d, v);
        check("R9 flush clear zeroes count", 64'(d), 64'(view(0, 0, 0)));
    endtask

    task automatic t_mask_and_clamp;
        logic [32:0] d; logic v;
        cfg(12, 2, 0);
        post(12, 'h15, 2);
        ack(12); ack(12);
        check("R2 high index bits ignored", 64'(fetch_req[12]), 64'h1);
        ack(12);
        check("R2 tail index+count masked", 64'(fetch_req[12]), 64'h0);
        cfg(11, 0, 0);
        post(11, 0, 5);
        ack(11);
        check("R10 size clamped to 4", 64'(fetch_req[11]), 64'h0);
        load(11, d, v);
        check("R10 clamped head", 64'(d), 64'(view(0, 0, 1)));
    endtask

    task automatic t_region;
        logic [32:0] d; logic v;
        post(9, 0, 3, 4);
        check("R1 foreign post ignored", 64'(fetch_req[9]), 64'h0);
        load(9, d, v, 6);
        check("R1 foreign load no answer", 64'(v), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_and_wrap();
        t_full_ring();
        t_wake();
        t_completion_flush();
        t_mask_and_clamp();
        t_region();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule